// File: doc/BRIEF.md
# Instruction Fetch and Next-Address Unit

This block holds the program counter of a single-cycle processor and drives it out as the instruction address. In the same cycle it returns the 32-bit instruction word stored at that address in a small read-only instruction store inside the block. At every rising clock edge it loads a new program counter. The value is chosen by a two-bit next-address select from the main decoder, the zero flag of the ALU, and the immediate and jump-target fields of the current instruction.

Three redirections are supported. The sequential path steps one word forward. A conditional branch moves by a signed word offset, but only when the ALU reports zero. A jump replaces the low 28 bits of the incremented address with the word-aligned target field. Every target is formed on word boundaries, so the two low address bits never leave zero. The control half turns the select code and the zero flag into a small set of redirect strobes. The datapath half builds the candidate addresses and holds the register.

Top module: `ifetch_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc` becomes 0 after that edge (synchronous reset).
- R2: With `nextSel` = 2'b00 (sequential), `pc` becomes `pc + 4` at the next edge.
- R3: With `nextSel` = 2'b01 (branch) and `aluZero` = 1, `pc` becomes `pc + 4 + (signext(imm16) << 2)`, modulo 2^32. Negative offsets move backwards.
- R4: With `nextSel` = 2'b01 and `aluZero` = 0, `pc` becomes `pc + 4`.
- R5: With `nextSel` = 2'b10 (jump), `pc` becomes `{(pc+4)[31:28], jumpTarget, 2'b00}`.
- R6: `pc[1:0]` is 2'b00 in every cycle after reset.
- R7: `instr` is the same-cycle combinational word at index k = `pc[ROM_AW+1:2]`, where the word is `(k * 32'h9E3779B1) ^ 32'h1F2E3D4C` taken to 32 bits, with ROM_AW = log2(ROM_DEPTH). Higher address bits do not take part in the index.
- R8: The unused code `nextSel` = 2'b11 behaves as sequential, so `pc` becomes `pc + 4`, whatever the values of `aluZero`, `imm16` and `jumpTarget`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nextSel | input | 2 | Next-address select: 00 sequential, 01 branch, 10 jump, 11 sequential |
| aluZero | input | 1 | ALU zero flag that qualifies a branch |
| imm16 | input | 16 | Signed word offset of a branch |
| jumpTarget | input | 26 | Word target field of a jump |
| pc | output | 32 | Current program counter / instruction address |
| instr | output | 32 | Instruction word fetched at `pc` |

## Verification
The checker tests on every cycle that each select code produces the right next address: sequential, taken branch, untaken branch, jump and the unused code. It also tests that the low address bits stay clear and that reset lands on zero. Only the bench scenarios show the content and indexing of the instruction store. The same is true of the wrap of backward and forward branches across the whole 32-bit space, and of jumps that keep a non-zero upper nibble taken from an earlier branch. The bench walks the full store sequentially and sweeps branch offsets and jump targets against an arithmetic model.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'b00,
    SEL_BRANCH = 2'b01,
    SEL_JUMP   = 2'b10,
    SEL_SPARE  = 2'b11
  } nextSel_e;

  typedef struct packed {
    logic takeBranch;
    logic takeJump;
  } ifuStrobes_t;

endpackage

// File: rtl/ifu_ctrl.sv
module ifu_ctrl
  import ifu_pkg::*;
(
  input  logic [1:0]  nextSel,
  input  logic        aluZero,
  output ifuStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    unique case (nextSel_e'(nextSel))
      SEL_BRANCH: strobes.takeBranch = aluZero;
      SEL_JUMP:   strobes.takeJump   = 1'b1;
      default:    strobes            = '0;
    endcase
  end

endmodule

// File: rtl/ifu_datapath.sv
module ifu_datapath
  import ifu_pkg::*;
#(
  parameter int          PC_W      = 32,
  parameter int          IMM_W     = 16,
  parameter int          TGT_W     = 26,
  parameter int          ROM_DEPTH = 64,
  parameter logic [31:0] ROM_MUL   = 32'h9E3779B1,
  parameter logic [31:0] ROM_XOR   = 32'h1F2E3D4C
) (
  input  logic               clk,
  input  logic               rst,
  input  ifuStrobes_t        strobes,
  input  logic [IMM_W-1:0]   imm16,
  input  logic [TGT_W-1:0]   jumpTarget,
  output logic [PC_W-1:0]    pc,
  output logic [31:0]        instr
);

  localparam int ROM_AW  = $clog2(ROM_DEPTH);
  localparam int EXT_W   = PC_W - IMM_W - 2;
  localparam int HIGH_W  = PC_W - TGT_W - 2;

  logic [PC_W-1:0] pcReg;
  logic [PC_W-1:0] pcPlus4;
  logic [PC_W-1:0] branchOfs;
  logic [PC_W-1:0] branchAddr;
  logic [PC_W-1:0] jumpAddr;
  logic [PC_W-1:0] pcNext;
  logic [31:0]     romWords [ROM_DEPTH];
  logic [ROM_AW-1:0] romIdx;

  assign pcPlus4    = pcReg + PC_W'(4);
  assign branchOfs  = {{EXT_W{imm16[IMM_W-1]}}, imm16, 2'b00};
  assign branchAddr = pcPlus4 + branchOfs;
  assign jumpAddr   = {pcPlus4[PC_W-1 -: HIGH_W], jumpTarget, 2'b00};

  always_comb begin
    if (strobes.takeJump)        pcNext = jumpAddr;
    else if (strobes.takeBranch) pcNext = branchAddr;
    else                         pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pcReg <= '0;
    else     pcReg <= pcNext;
  end

  for (genvar k = 0; k < ROM_DEPTH; k++) begin : g_rom
    assign romWords[k] = (32'(k) * ROM_MUL) ^ ROM_XOR;
  end

  assign romIdx = pcReg[ROM_AW+1:2];
  assign instr  = romWords[romIdx];
  assign pc     = pcReg;

endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
  import ifu_pkg::*;
#(
  parameter int ROM_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  nextSel,
  input  logic        aluZero,
  input  logic [15:0] imm16,
  input  logic [25:0] jumpTarget,
  output logic [31:0] pc,
  output logic [31:0] instr
);

  ifuStrobes_t strobes;

  ifu_ctrl u_ctrl (
    .nextSel (nextSel),
    .aluZero (aluZero),
    .strobes (strobes)
  );

  ifu_datapath #(
    .PC_W      (32),
    .IMM_W     (16),
    .TGT_W     (26),
    .ROM_DEPTH (ROM_DEPTH)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .imm16      (imm16),
    .jumpTarget (jumpTarget),
    .pc         (pc),
    .instr      (instr)
  );

endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  nextSel,
  input logic        aluZero,
  input logic [15:0] imm16,
  input logic [25:0] jumpTarget,
  input logic [31:0] pc
);

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (pc == 32'd0));

  // R6
  aligned_pc_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (pc[1:0] == 2'b00));

  // R2
  seq_next_chk: assert property (@(posedge clk) disable iff (rst)
    (nextSel == 2'b00) |=> (pc == $past(pc) + 32'd4));

  // R3
  branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (nextSel == 2'b01 && aluZero) |=>
      (pc == $past(pc) + 32'd4 + {{14{$past(imm16[15])}}, $past(imm16), 2'b00}));

  // R4
  branch_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (nextSel == 2'b01 && !aluZero) |=> (pc == $past(pc) + 32'd4));

  // R5
  jump_next_chk: assert property (@(posedge clk) disable iff (rst)
    (nextSel == 2'b10) |=>
      (pc == ((($past(pc) + 32'd4) & 32'hF000_0000) | {4'b0, $past(jumpTarget), 2'b00})));

  // R8
  spare_code_chk: assert property (@(posedge clk) disable iff (rst)
    (nextSel == 2'b11) |=> (pc == $past(pc) + 32'd4));

endmodule

bind ifetch_unit ifetch_unit_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .nextSel    (nextSel),
  .aluZero    (aluZero),
  .imm16      (imm16),
  .jumpTarget (jumpTarget),
  .pc         (pc)
);

// File: tb/ifetch_unit_bench.sv
`timescale 1ns/1ps
module ifetch_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  nextSel = 2'b00;
  logic        aluZero = 1'b0;
  logic [15:0] imm16 = '0;
  logic [25:0] jumpTarget = '0;
  logic [31:0] pc;
  logic [31:0] instr;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [31:0] expPc = '0;

  always #2 clk = ~clk;

  ifetch_unit u_ifetch_unit (
    .clk        (clk),
    .rst        (rst),
    .nextSel    (nextSel),
    .aluZero    (aluZero),
    .imm16      (imm16),
    .jumpTarget (jumpTarget),
    .pc         (pc),
    .instr      (instr)
  );

  function automatic logic [31:0] romWord(logic [31:0] addr);
    logic [31:0] k;
    k = {26'd0, addr[7:2]};
    return (k * 32'h9E3779B1) ^ 32'h1F2E3D4C;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic [1:0] sel, logic z,
                      logic [15:0] im, logic [25:0] tg);
    logic [31:0] p4;
    nextSel = sel; aluZero = z; imm16 = im; jumpTarget = tg;
    p4 = expPc + 32'd4;
    case (sel)
      2'b01:   expPc = z ? p4 + {{14{im[15]}}, im, 2'b00} : p4;
      2'b10:   expPc = {p4[31:28], tg, 2'b00};
      default: expPc = p4;
    endcase
    @(posedge clk);
    @(negedge clk);
    check(req, pc, expPc);
    check("R6", {30'd0, pc[1:0]}, 32'd0);
    check("R7", instr, romWord(expPc));
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    expPc = '0;
    check("R1", pc, 32'd0);
    check("R7", instr, romWord(32'd0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog R1: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();

    // R2 / R7: walk the whole store twice so the index wraps
    for (int i = 0; i < 130; i++) step("R2", 2'b00, i[0], 16'(i * 37), 26'(i));

    // R3 / R4: sweep offsets, both polarities of the zero flag
    for (int i = 0; i < 64; i++) begin
      logic [15:0] ofs;
      ofs = 16'(i * 1031) ^ (i[0] ? 16'h8000 : 16'h0000);
      step("R4", 2'b01, 1'b0, ofs, 26'h3FF_FFFF);
      step("R3", 2'b01, 1'b1, ofs, 26'h3FF_FFFF);
    end

    // R3: extreme offsets
    step("R3", 2'b01, 1'b1, 16'h8000, '0);
    step("R3", 2'b01, 1'b1, 16'h7FFF, '0);
    step("R3", 2'b01, 1'b1, 16'hFFFF, '0);

    // R5: jumps with the upper nibble taken from the incremented pc
    for (int i = 0; i < 32; i++) begin
      step("R5", 2'b10, i[1], 16'hFFFF, 26'(i * 32'h0012_3457));
      step("R3", 2'b01, 1'b1, 16'(16'h8000 + i), '0);
    end
    step("R5", 2'b10, 1'b1, '0, 26'h3FF_FFFF);
    step("R5", 2'b10, 1'b0, '0, 26'h000_0000);

    // R8: spare code ignores the zero flag, offset and target
    for (int i = 0; i < 16; i++) step("R8", 2'b11, 1'b1, 16'h1234, 26'h2AA_AAAA);

    // R1: reset in the middle of a run
    step("R2", 2'b00, 1'b0, '0, '0);
    doReset();
    step("R2", 2'b00, 1'b0, '0, '0);
    check("R2", pc, 32'd4);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule